// File: doc/BRIEF.md
# Channel-Selective Output Capture

This block sits after an 8-bit analog-to-digital converter whose results leave the chip as a stream of byte-wide words. It packs successive words into 16-bit samples and presents each sample on a 16-bit data bus. A one-cycle qualifying strobe accompanies the samples, and its rising edge tells a downstream logic analyzer or capture register when the bus holds a valid value.

In three-colour operation the converter interleaves samples in a fixed red, green, blue rotation. A 2-bit grab setting lets the strobe fire for every sample or for one colour only. The data bus still shows every sample, but an instrument clocked by the strobe records a single colour plane. A line-start pulse realigns both the colour rotation and the byte pairing at the beginning of each scan line. In one-colour operation every sample is qualified.

Top module: `chan_capture`

## Requirements
- R1: Asynchronous active-low reset sets `data_o` to zero and `latch_o` low. It clears the byte phase so that the next accepted word is treated as an upper byte, and it returns the colour rotation to red.
- R2: Two accepted words (`word_valid_i` high at a clock edge) form one sample. The first word is bits 15:8 and the second is bits 7:0. Any number of idle cycles may separate the two words.
- R3: `data_o` takes the new sample in the cycle after the edge that accepts the sample's second word. `latch_o` rises one cycle later, so the data is on the bus one full cycle before the rising edge of the strobe.
- R4: `latch_o` stays high for exactly one cycle per qualified sample, and `data_o` does not change while it is high.
- R5: With `tri_mode_i` low (one colour), every sample is qualified whatever the value of `grab_sel_i`.
- R6: With `tri_mode_i` high and `grab_sel_i` = 2'b00, every sample is qualified.
- R7: With `tri_mode_i` high, samples are assigned red, green, blue, red and so on, in order. `grab_sel_i` = 2'b01 qualifies only red samples, 2'b10 only green samples and 2'b11 only blue samples.
- R8: `line_start_i` high at an edge returns the rotation to red and discards a pending upper byte. A word accepted at that same edge is taken as the upper byte of a new sample.
- R9: `data_o` shows every completed sample, including samples that do not qualify for a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 8 | Converter output word |
| word_valid_i | input | 1 | Qualifies `word_i` at the clock edge |
| tri_mode_i | input | 1 | 1: three interleaved colours, 0: one colour |
| grab_sel_i | input | 2 | 00 all, 01 red, 10 green, 11 blue |
| line_start_i | input | 1 | Line-start pulse, restarts colour rotation and byte pairing |
| data_o | output | 16 | Assembled sample |
| latch_o | output | 1 | Qualifying strobe, data valid at its rising edge |

## Verification
The bench builds the block with its default widths: 8-bit words and 16-bit samples, which gives two words per sample. With these widths the strobe pulse and the following sample update can fall on neighbouring edges, and the single-cycle pulse and data-stability checks depend on that. Back-to-back word pairs produce the densest strobe pattern, and spaced words test that a pending upper byte is held. A line start or reset arriving between the two words of a sample shows whether byte realignment works. Six-sample runs under each grab code show the full colour rotation twice.

// File: rtl/capture_pkg.sv
`timescale 1ns/1ps
package capture_pkg;
  // colour code doubles as the grab code that selects it; 2'b00 means all
  typedef enum logic [1:0] {
    COL_ANY   = 2'b00,
    COL_RED   = 2'b01,
    COL_GREEN = 2'b10,
    COL_BLUE  = 2'b11
  } colour_e;
endpackage

// File: rtl/word_packer.sv
`timescale 1ns/1ps
module word_packer #(
  parameter int WORD_W   = 8,
  parameter int SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                valid_i,
  input  logic [WORD_W-1:0]   word_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                done_o
);
  localparam int WORDS = SAMPLE_W / WORD_W;

  logic [SAMPLE_W-1:0] sample_q;
  logic                done_q;

  if (WORDS == 1) begin : g_direct
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sample_q <= '0;
        done_q   <= 1'b0;
      end else begin
        done_q <= valid_i;
        if (valid_i) sample_q <= SAMPLE_W'(word_i);
      end
    end
  end else begin : g_packed
    localparam int PW = $clog2(WORDS);
    logic [PW-1:0]       phase_q;
    logic [SAMPLE_W-1:0] shift_q;
    logic                last;

    assign last = valid_i && !clear_i && (phase_q == PW'(WORDS - 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        phase_q  <= '0;
        shift_q  <= '0;
        sample_q <= '0;
        done_q   <= 1'b0;
      end else begin
        done_q <= last;
        if (valid_i) shift_q <= {shift_q[SAMPLE_W-WORD_W-1:0], word_i};
        if (last) sample_q <= {shift_q[SAMPLE_W-WORD_W-1:0], word_i};
        // a word arriving with clear starts a fresh sample
        if (clear_i)      phase_q <= valid_i ? PW'(1) : '0;
        else if (last)    phase_q <= '0;
        else if (valid_i) phase_q <= phase_q + PW'(1);
      end
    end
  end

  assign sample_o = sample_q;
  assign done_o   = done_q;
endmodule

// File: rtl/colour_seq.sv
`timescale 1ns/1ps
module colour_seq
  import capture_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    restart_i,
  input  logic    step_i,
  input  logic    tri_mode_i,
  output colour_e colour_o
);
  colour_e col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) col_q <= COL_RED;
    else if (restart_i) col_q <= COL_RED;
    else if (step_i && tri_mode_i) begin
      unique case (col_q)
        COL_RED:   col_q <= COL_GREEN;
        COL_GREEN: col_q <= COL_BLUE;
        default:   col_q <= COL_RED;
      endcase
    end
  end

  assign colour_o = col_q;
endmodule

// File: rtl/latch_gate.sv
`timescale 1ns/1ps
module latch_gate
  import capture_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       done_i,
  input  logic       tri_mode_i,
  input  logic [1:0] grab_i,
  input  colour_e    colour_i,
  output logic       latch_o
);
  logic qualify;
  logic latch_q;

  assign qualify = !tri_mode_i
                || (colour_e'(grab_i) == COL_ANY)
                || (colour_e'(grab_i) == colour_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) latch_q <= 1'b0;
    else         latch_q <= done_i && qualify;
  end

  assign latch_o = latch_q;
endmodule

// File: rtl/chan_capture.sv
`timescale 1ns/1ps
module chan_capture
  import capture_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [WORD_W-1:0]   word_i,
  input  logic                word_valid_i,
  input  logic                tri_mode_i,
  input  logic [1:0]          grab_sel_i,
  input  logic                line_start_i,
  output logic [SAMPLE_W-1:0] data_o,
  output logic                latch_o
);
  logic    done;
  colour_e colour;

  word_packer #(
    .WORD_W  (WORD_W),
    .SAMPLE_W(SAMPLE_W)
  ) u_packer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (line_start_i),
    .valid_i (word_valid_i),
    .word_i  (word_i),
    .sample_o(data_o),
    .done_o  (done)
  );

  // colour of the sample flagged by done; it advances on the same edge the strobe is set
  colour_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (line_start_i),
    .step_i    (done),
    .tri_mode_i(tri_mode_i),
    .colour_o  (colour)
  );

  latch_gate u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (done),
    .tri_mode_i(tri_mode_i),
    .grab_i    (grab_sel_i),
    .colour_i  (colour),
    .latch_o   (latch_o)
  );
endmodule

// File: rtl/chan_capture_chk.sv
`timescale 1ns/1ps
module chan_capture_chk #(
  parameter int WORD_W   = 8,
  parameter int SAMPLE_W = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                word_valid_i,
  input logic [SAMPLE_W-1:0] data_o,
  input logic                latch_o
);
  localparam int WORDS = SAMPLE_W / WORD_W;

  // R1
  reset_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> (!latch_o && data_o == '0));

  // R3
  strobe_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |-> $past(word_valid_i, 2));

  // R4
  hold_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |-> $stable(data_o));

  if (WORDS > 1) begin : g_multi
    // R4
    single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      latch_o |=> !latch_o);
  end
endmodule

bind chan_capture chan_capture_chk #(
  .WORD_W  (WORD_W),
  .SAMPLE_W(SAMPLE_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .word_valid_i(word_valid_i),
  .data_o      (data_o),
  .latch_o     (latch_o)
);

// File: tb/chan_capture_tb_top.sv
`timescale 1ns/1ps
module chan_capture_tb_top;
  localparam int WORD_W   = 8;
  localparam int SAMPLE_W = 16;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [WORD_W-1:0]   word = '0;
  logic                valid = 1'b0;
  logic                tri_mode = 1'b0;
  logic [1:0]          grab = 2'b00;
  logic                line_start = 1'b0;
  logic [SAMPLE_W-1:0] data_o;
  logic                latch_o;

  always #2.5 clk = ~clk;

  chan_capture #(.WORD_W(WORD_W), .SAMPLE_W(SAMPLE_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .word_i(word), .word_valid_i(valid),
    .tri_mode_i(tri_mode), .grab_sel_i(grab), .line_start_i(line_start),
    .data_o(data_o), .latch_o(latch_o)
  );

  int total = 0, bad = 0;
  int mon_total = 0, mon_bad = 0;
  int ncap = 0;
  logic [SAMPLE_W-1:0] cap [0:63];
  logic                lat_prev = 1'b0;
  logic [SAMPLE_W-1:0] dat_prev = '0;

  // strobe monitor: R3 setup before rising edge, R4 single-cycle pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (latch_o && !lat_prev) begin
        if (ncap < 64) cap[ncap] = data_o;
        ncap = ncap + 1;
        mon_total = mon_total + 1;
        if (data_o !== dat_prev) begin
          mon_bad = mon_bad + 1;
          $display("FAIL R3 setup: data at strobe %h, one cycle earlier %h", data_o, dat_prev);
        end
      end
      if (latch_o && lat_prev) begin
        mon_total = mon_total + 1;
        mon_bad = mon_bad + 1;
        $display("FAIL R4 width: strobe high %0d cycles, expected 1", 2);
      end
    end
    lat_prev = latch_o;
    dat_prev = data_o;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [SAMPLE_W-1:0] smp(input int k);
    return {8'(8'h31 + 8'(k * 7)), 8'(8'hC2 + 8'(k * 13))};
  endfunction

  task automatic put_word(input logic [WORD_W-1:0] w);
    @(posedge clk); #1 word = w; valid = 1'b1;
    @(posedge clk); #1 valid = 1'b0;
  endtask

  task automatic put_pair(input logic [SAMPLE_W-1:0] s);
    @(posedge clk); #1 word = s[15:8]; valid = 1'b1;
    @(posedge clk); #1 word = s[7:0];
    @(posedge clk); #1 valid = 1'b0;
  endtask

  task automatic restart();
    @(posedge clk); #1 line_start = 1'b1;
    @(posedge clk); #1 line_start = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_caps(input int base, input int n, input logic [SAMPLE_W-1:0] e [0:7], input string req);
    chk((ncap - base) == n, req, 32'(ncap - base), 32'(n));
    for (int i = 0; i < n && i < 8; i++)
      if (base + i < 64) chk(cap[base + i] === e[i], req, 32'(cap[base + i]), 32'(e[i]));
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(data_o === '0, "R1 data", 32'(data_o), 32'h0);
    chk(latch_o === 1'b0, "R1 latch", 32'(latch_o), 32'h0);
  endtask

  // R2 byte order, R3 cycle timing
  task automatic test_timing();
    tri_mode = 1'b0; grab = 2'b00;
    restart();
    @(posedge clk); #1 word = 8'h12; valid = 1'b1;
    @(posedge clk); #1 word = 8'h34;
    @(posedge clk); #1 valid = 1'b0;
    @(negedge clk);
    chk(data_o === 16'h1234, "R2 order", 32'(data_o), 32'h1234);
    chk(latch_o === 1'b0, "R3 strobe not yet", 32'(latch_o), 32'h0);
    @(negedge clk);
    chk(latch_o === 1'b1, "R3 strobe rises", 32'(latch_o), 32'h1);
    @(negedge clk);
    chk(latch_o === 1'b0, "R4 strobe falls", 32'(latch_o), 32'h0);
  endtask

  // R5 one-colour mode ignores grab
  task automatic test_single();
    logic [SAMPLE_W-1:0] e [0:7];
    int base;
    tri_mode = 1'b0; grab = 2'b11;
    restart();
    base = ncap;
    for (int k = 0; k < 4; k++) begin e[k] = smp(k); put_pair(smp(k)); end
    for (int k = 4; k < 8; k++) e[k] = '0;
    settle();
    expect_caps(base, 4, e, "R5 single");
  endtask

  // R6 all, R7 per colour
  task automatic test_grab(input logic [1:0] g);
    logic [SAMPLE_W-1:0] e [0:7];
    int base, n;
    string req;
    tri_mode = 1'b1; grab = g;
    req = (g == 2'b00) ? "R6 all" : "R7 colour";
    restart();
    base = ncap; n = 0;
    for (int k = 0; k < 8; k++) e[k] = '0;
    for (int k = 0; k < 6; k++) begin
      put_pair(smp(k + 8 * int'(g)));
      if (g == 2'b00 || (k % 3) == int'(g) - 1) begin e[n] = smp(k + 8 * int'(g)); n++; end
    end
    settle();
    expect_caps(base, n, e, req);
  endtask

  // R9 bus shows unqualified samples
  task automatic test_bus();
    logic [SAMPLE_W-1:0] e [0:7];
    int base;
    tri_mode = 1'b1; grab = 2'b01;
    restart();
    base = ncap;
    for (int k = 0; k < 8; k++) e[k] = '0;
    e[0] = smp(40);
    put_pair(smp(40)); put_pair(smp(41)); put_pair(smp(42));
    settle();
    chk(data_o === smp(42), "R9 bus", 32'(data_o), 32'(smp(42)));
    expect_caps(base, 1, e, "R9 strobe");
  endtask

  // R8 line start: rotation and byte phase
  task automatic test_line_start();
    logic [SAMPLE_W-1:0] e [0:7];
    int base;
    for (int k = 0; k < 8; k++) e[k] = '0;
    tri_mode = 1'b1; grab = 2'b11;
    restart();
    base = ncap;
    put_pair(smp(50));
    restart();
    put_pair(smp(51)); put_pair(smp(52)); put_pair(smp(53));
    settle();
    e[0] = smp(53);
    expect_caps(base, 1, e, "R8 rotation");
    tri_mode = 1'b0;
    base = ncap;
    put_word(8'hEE);
    restart();
    put_pair(16'h5AA5);
    settle();
    e[0] = 16'h5AA5;
    expect_caps(base, 1, e, "R8 phase");
    chk(data_o === 16'h5AA5, "R8 bus", 32'(data_o), 32'h5AA5);
  endtask

  // R2 idle cycles between words
  task automatic test_gap();
    logic [SAMPLE_W-1:0] e [0:7];
    int base;
    for (int k = 0; k < 8; k++) e[k] = '0;
    tri_mode = 1'b0; grab = 2'b00;
    restart();
    base = ncap;
    put_word(8'hB7);
    repeat (3) @(posedge clk);
    put_word(8'h4D);
    settle();
    e[0] = 16'hB74D;
    expect_caps(base, 1, e, "R2 gap");
  endtask

  // R1 reset mid-sample realigns bytes and colour
  task automatic test_reset_mid();
    logic [SAMPLE_W-1:0] e [0:7];
    int base;
    for (int k = 0; k < 8; k++) e[k] = '0;
    tri_mode = 1'b1; grab = 2'b00;
    put_pair(smp(60));
    put_word(8'h99);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(data_o === '0, "R1 mid data", 32'(data_o), 32'h0);
    rst_n = 1'b1;
    grab = 2'b01;
    base = ncap;
    put_pair(16'hC3E1);
    settle();
    e[0] = 16'hC3E1;
    expect_caps(base, 1, e, "R1 realign");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    test_reset();
    test_timing();
    test_single();
    test_grab(2'b00);
    test_grab(2'b01);
    test_grab(2'b10);
    test_grab(2'b11);
    test_bus();
    test_line_start();
    test_gap();
    test_reset_mid();
    repeat (4) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog: run hung, actual %0d expected %0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total + mon_total + 1, bad + mon_bad + 1);
    $finish;
  end
endmodule